// File: doc/BRIEF.md
# PWM Timer Compare Output Unit

This block is a free-running timer with one compare channel. The channel drives a single waveform bit onto an output pin. A 2-bit waveform-mode input picks how the counter runs:

- plain overflow counting
- clear-on-match counting, where the period is set by the compare value
- single-slope fast PWM
- dual-slope phase-correct PWM

A 2-bit output-mode input picks what the waveform bit does at a compare match and at TOP. The same output-mode code means different actions in different waveform modes. In phase-correct mode the action also depends on the count direction.

The pin falls back to an ordinary port value when the output mode is off, or when the direction enable is low. The compare value is loaded through a write strobe. In the two PWM modes it is double-buffered and takes effect only at TOP. The counter can be written directly. A write to the counter suppresses the compare match in the cycle that follows the write.

Top module: `pwm_compare_unit`

## Requirements
- R1: With output mode 2'b00 the override flag is 0 and the pin equals `port_val` in every waveform mode.
- R2: With a nonzero output mode the override flag is 1. The pin carries the waveform bit when `dir_en` is 1 and `port_val` when `dir_en` is 0.
- R3: In waveform modes 2'b00 (overflow) and 2'b01 (clear-on-match), a compare match does the following to the waveform bit, depending on the output mode:
  - 2'b01 toggles it
  - 2'b10 clears it
  - 2'b11 sets it
- R4: In overflow mode the counter runs 0 to 2^W-1 and wraps. In clear-on-match mode it runs 0 to the compare value C and wraps. With toggle selected, the pin therefore changes every 2^W cycles in overflow mode and every C+1 cycles in clear-on-match mode.
- R5: Fast PWM (waveform mode 2'b10) counts 0 to 2^W-1 and wraps. Output mode 2'b10 sets the bit at TOP and clears it on a match, giving C+1 high cycles per 2^W. Output mode 2'b11 does the reverse, giving 2^W-1-C high cycles.
- R6: Phase-correct PWM (waveform mode 2'b11) counts up from 0 to 2^W-1 and then back down to 0, a period of 2*(2^W-1) cycles. Output mode 2'b10 clears the bit on an up-count match and sets it on a down-count match, giving 2C high cycles for 1 <= C <= 2^W-1. Output mode 2'b11 does the reverse, giving 2*(2^W-1)-2C high cycles.
- R7: In both PWM modes, output mode 2'b01 is reserved and leaves the waveform bit unchanged.
- R8: In the PWM modes, when C equals 2^W-1 and the upper output-mode bit is set, the match is ignored and only the TOP action applies. The pin is then always high for code 2'b10 and always low for code 2'b11.
- R9: In the PWM modes a compare write lands in a buffer and becomes active when the counter reaches TOP (while counting up). In the other modes a write is active from the next cycle.
- R10: The compare match is suppressed in the cycle right after a counter write.
- R11: Reset clears the counter, the count direction, the compare value and the waveform bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wave_mode | input | 2 | Waveform mode: 00 overflow, 01 clear-on-match, 10 fast PWM, 11 phase-correct PWM |
| out_mode | input | 2 | Output mode code (R3, R5 to R8) |
| cmp_wr_en | input | 1 | Compare value write strobe |
| cmp_wr_data | input | CNT_W | Compare value to write |
| cnt_wr_en | input | 1 | Counter write strobe |
| cnt_wr_data | input | CNT_W | Counter value to write |
| dir_en | input | 1 | Pin direction enable |
| port_val | input | 1 | Fallback port data |
| pin_val | output | 1 | Value on the pin |
| override | output | 1 | High when the waveform has taken over the pin |

## Verification
A wrong counter or direction state shows up as a wrong period or a wrong duty. Either error becomes visible at the pin within one PWM period: 2^W cycles in fast PWM, or 2*(2^W-1) cycles in phase-correct mode. A stale or early compare value shifts a pulse edge, so the high time differs in the first period after the write. A missed match suppression makes the pin toggle one cycle after a counter write, instead of a full period later. The bench sweeps every compare value on a 4-bit counter in each mode and checks the high count and the edge spacing against closed-form formulas.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;
   typedef enum logic [1:0] {
      WM_NORMAL    = 2'b00,
      WM_CLR_MATCH = 2'b01,
      WM_FAST      = 2'b10,
      WM_PHASE     = 2'b11
   } wave_mode_e;

   typedef enum logic [1:0] {
      OM_OFF    = 2'b00,
      OM_TOGGLE = 2'b01,
      OM_CLEAR  = 2'b10,
      OM_SET    = 2'b11
   } out_mode_e;

   function automatic logic is_pwm(wave_mode_e m);
      return (m == WM_FAST) || (m == WM_PHASE);
   endfunction
endpackage

// File: rtl/pwm_cnt_core.sv
module pwm_cnt_core
   import pwm_cmp_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  wave_mode_e       mode,
   input  logic [CNT_W-1:0] cmp_act,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] cnt,
   output logic             cnt_down,
   output logic             at_top
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] top_val;
   logic [CNT_W-1:0] cnt_nxt;
   logic             down_nxt;

   assign top_val = (mode == WM_CLR_MATCH) ? cmp_act : CNT_MAX;
   assign at_top  = (cnt == top_val) && !cnt_down;

   always_comb begin
      cnt_nxt  = cnt + CNT_ONE;
      down_nxt = 1'b0;
      if (mode == WM_PHASE) begin
         if (cnt_down) begin
            if (cnt == '0) begin
               cnt_nxt  = CNT_ONE;
               down_nxt = 1'b0;
            end else begin
               cnt_nxt  = cnt - CNT_ONE;
               down_nxt = 1'b1;
            end
         end else if (at_top) begin
            cnt_nxt  = cnt - CNT_ONE;
            down_nxt = 1'b1;
         end
      end else if (at_top) begin
         cnt_nxt = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         cnt_down <= 1'b0;
      end else if (wr_en) begin
         cnt      <= wr_data;
         cnt_down <= cnt_down && (mode == WM_PHASE);
      end else begin
         cnt      <= cnt_nxt;
         cnt_down <= down_nxt;
      end
   end

   // R5: fast PWM wraps from the all-ones value to zero
   assert_fast_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == WM_FAST && cnt == CNT_MAX && !wr_en) |=> (cnt == '0));

   // R6: phase-correct turns back up at zero
   assert_phase_turn_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == WM_PHASE && cnt_down && cnt == '0 && !wr_en) |=> (cnt == CNT_ONE && !cnt_down));

   // R4: clear-on-match restarts after reaching the compare value
   assert_ctc_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == WM_CLR_MATCH && cnt == cmp_act && !wr_en) |=> (cnt == '0));
endmodule

// File: rtl/pwm_cmp_buf.sv
module pwm_cmp_buf
   import pwm_cmp_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  wave_mode_e       mode,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             at_top,
   output logic [CNT_W-1:0] cmp_act
);
   logic [CNT_W-1:0] cmp_buf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_buf <= '0;
         cmp_act <= '0;
      end else begin
         if (wr_en) cmp_buf <= wr_data;
         if (!is_pwm(mode)) begin
            if (wr_en) cmp_act <= wr_data;
         end else if (at_top) begin
            cmp_act <= cmp_buf;
         end
      end
   end

   // R9: buffered value holds between TOP events in the PWM modes
   assert_buf_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (is_pwm(mode) && !at_top) |=> $stable(cmp_act));

   // R9: non-PWM writes apply at once
   assert_direct_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_pwm(mode) && wr_en) |=> (cmp_act == $past(wr_data)));
endmodule

// File: rtl/pwm_wave_gen.sv
module pwm_wave_gen
   import pwm_cmp_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  wave_mode_e       mode,
   input  out_mode_e        om,
   input  logic [CNT_W-1:0] cnt,
   input  logic             cnt_down,
   input  logic             at_top,
   input  logic [CNT_W-1:0] cmp_act,
   input  logic             cnt_wr_en,
   output logic             wave
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic supp_q;
   logic match;
   logic special;
   logic hit;
   logic wave_nxt;

   assign match   = (cnt == cmp_act) && !supp_q;
   assign special = is_pwm(mode) && om[1] && (cmp_act == CNT_MAX);
   assign hit     = match && !special;

   always_comb begin
      wave_nxt = wave;
      unique case (mode)
         WM_NORMAL, WM_CLR_MATCH: begin
            if (match) begin
               unique case (om)
                  OM_TOGGLE: wave_nxt = !wave;
                  OM_CLEAR:  wave_nxt = 1'b0;
                  OM_SET:    wave_nxt = 1'b1;
                  default:   wave_nxt = wave;
               endcase
            end
         end
         WM_FAST: begin
            if (at_top && om[1]) wave_nxt = (om == OM_CLEAR);
            if (hit && om[1])    wave_nxt = (om == OM_SET);
         end
         default: begin
            if (at_top && special) wave_nxt = (om == OM_CLEAR);
            if (hit && om[1])      wave_nxt = (om == OM_SET) ^ cnt_down;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         supp_q <= 1'b0;
         wave   <= 1'b0;
      end else begin
         supp_q <= cnt_wr_en;
         wave   <= wave_nxt;
      end
   end

   // R10: no match in the cycle after a counter write
   assert_no_match_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr_en |=> !match);

   // R3: set-on-match in the non-PWM modes
   assert_nonpwm_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_pwm(mode) && match && om == OM_SET) |=> wave);

   // R8: compare at TOP with clear code keeps the output high
   assert_top_special_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == WM_FAST && special && at_top && om == OM_CLEAR) |=> wave);

   // R7: reserved code in PWM modes holds the output
   assert_reserved_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (is_pwm(mode) && om == OM_TOGGLE) |=> $stable(wave));
endmodule

// File: rtl/pwm_compare_unit.sv
module pwm_compare_unit
   import pwm_cmp_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter bit PHASE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       wave_mode,
   input  logic [1:0]       out_mode,
   input  logic             cmp_wr_en,
   input  logic [CNT_W-1:0] cmp_wr_data,
   input  logic             cnt_wr_en,
   input  logic [CNT_W-1:0] cnt_wr_data,
   input  logic             dir_en,
   input  logic             port_val,
   output logic             pin_val,
   output logic             override
);
   wave_mode_e       mode_in;
   wave_mode_e       mode_eff;
   out_mode_e        om;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cmp_act;
   logic             cnt_down;
   logic             at_top;
   logic             wave;

   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_width
         $error("pwm_compare_unit: CNT_W must lie in 2..16");
      end
      if (PHASE_EN) begin : g_phase
         assign mode_eff = mode_in;
      end else begin : g_no_phase
         assign mode_eff = (mode_in == WM_PHASE) ? WM_FAST : mode_in;
      end
   endgenerate

   assign mode_in = wave_mode_e'(wave_mode);
   assign om      = out_mode_e'(out_mode);

   pwm_cnt_core #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .mode(mode_eff), .cmp_act(cmp_act),
      .wr_en(cnt_wr_en), .wr_data(cnt_wr_data),
      .cnt(cnt), .cnt_down(cnt_down), .at_top(at_top)
   );

   pwm_cmp_buf #(.CNT_W(CNT_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .mode(mode_eff),
      .wr_en(cmp_wr_en), .wr_data(cmp_wr_data),
      .at_top(at_top), .cmp_act(cmp_act)
   );

   pwm_wave_gen #(.CNT_W(CNT_W)) u_wave (
      .clk(clk), .rst_n(rst_n), .mode(mode_eff), .om(om),
      .cnt(cnt), .cnt_down(cnt_down), .at_top(at_top),
      .cmp_act(cmp_act), .cnt_wr_en(cnt_wr_en), .wave(wave)
   );

   assign override = |out_mode;
   assign pin_val  = (override && dir_en) ? wave : port_val;

   // R1: disconnected output leaves the port value on the pin
   assert_port_fallback_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (out_mode == 2'b00) |-> (pin_val == port_val && !override));

   // R2: without direction enable the pin keeps port data
   assert_dir_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_mode != 2'b00 && !dir_en) |-> (pin_val == port_val && override));
endmodule

// File: tb/tb_pwm_compare_unit.sv
module tb_pwm_compare_unit;
   localparam int W     = 4;
   localparam int FPER  = 1 << W;
   localparam int PPER  = 2 * ((1 << W) - 1);

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   wave_mode = 2'b00;
   logic [1:0]   out_mode = 2'b00;
   logic         cmp_wr_en = 1'b0;
   logic [W-1:0] cmp_wr_data = '0;
   logic         cnt_wr_en = 1'b0;
   logic [W-1:0] cnt_wr_data = '0;
   logic         dir_en = 1'b0;
   logic         port_val = 1'b1;
   logic         pin_val;
   logic         override;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pwm_compare_unit #(.CNT_W(W), .PHASE_EN(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .wave_mode(wave_mode), .out_mode(out_mode),
      .cmp_wr_en(cmp_wr_en), .cmp_wr_data(cmp_wr_data),
      .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
      .dir_en(dir_en), .port_val(port_val),
      .pin_val(pin_val), .override(override)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wr_cmp(input int v);
      cmp_wr_en   = 1'b1;
      cmp_wr_data = W'(v);
      @(negedge clk);
      cmp_wr_en   = 1'b0;
   endtask

   task automatic count_high(input int n, output int h);
      h = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (pin_val) h++;
      end
   endtask

   task automatic measure_gap(output int g);
      logic p;
      int n;
      p = pin_val; n = 0;
      while (pin_val == p && n < 200) begin @(negedge clk); n++; end
      p = pin_val; n = 0;
      while (pin_val == p && n < 200) begin @(negedge clk); n++; end
      g = n;
   endtask

   task automatic wait_change(output int n);
      logic p;
      p = pin_val; n = 0;
      while (pin_val == p && n < 200) begin @(negedge clk); n++; end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int h, g, n, prev;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 override off after reset", int'(override), 0);
      chk("R1 pin follows port high", int'(pin_val), 1);
      port_val = 1'b0;
      @(negedge clk);
      chk("R1 pin follows port low", int'(pin_val), 0);

      out_mode = 2'b10; port_val = 1'b1;
      @(negedge clk);
      chk("R2 override set", int'(override), 1);
      chk("R2 no dir_en keeps port", int'(pin_val), 1);
      dir_en = 1'b1;
      @(negedge clk);
      chk("R11 waveform bit reset low", int'(pin_val), 0);

      // R3 non-PWM set / clear / toggle in overflow mode
      wr_cmp(5);
      out_mode = 2'b11;
      repeat (20) @(negedge clk);
      chk("R3 set on match", int'(pin_val), 1);
      out_mode = 2'b10;
      repeat (20) @(negedge clk);
      chk("R3 clear on match", int'(pin_val), 0);
      out_mode = 2'b01;
      measure_gap(g);
      chk("R3 R4 toggle spacing overflow", g, FPER);

      // R10 counter write suppresses the following match
      wait_change(n);
      cnt_wr_en = 1'b1; cnt_wr_data = W'(5);
      @(negedge clk);
      cnt_wr_en = 1'b0;
      n = 1;
      prev = int'(pin_val);
      while (int'(pin_val) == prev && n < 100) begin @(negedge clk); n++; end
      chk("R10 match suppressed after write", n, 18);
      cnt_wr_en = 1'b1; cnt_wr_data = W'(4);
      @(negedge clk);
      cnt_wr_en = 1'b0;
      n = 1;
      prev = int'(pin_val);
      while (int'(pin_val) == prev && n < 100) begin @(negedge clk); n++; end
      chk("R10 match after unsuppressed step", n, 3);

      // R4 R9 clear-on-match period sweep, immediate compare load
      wave_mode = 2'b01;
      for (int c = 1; c < FPER; c++) begin
         wr_cmp(c);
         repeat (40) @(negedge clk);
         measure_gap(g);
         chk($sformatf("R4 R9 ctc period c=%0d", c), g, c + 1);
      end

      // R5 R8 fast PWM sweep
      wave_mode = 2'b10;
      for (int m = 2; m < 4; m++) begin
         out_mode = 2'(m);
         for (int c = 0; c < FPER; c++) begin
            wr_cmp(c);
            repeat (3 * FPER) @(negedge clk);
            count_high(FPER, h);
            chk($sformatf("%s fast mode=%0d c=%0d", (c == FPER - 1) ? "R8" : "R5", m, c),
                h, (m == 2) ? c + 1 : FPER - 1 - c);
         end
      end

      // R7 reserved code in fast PWM
      out_mode = 2'b01;
      @(negedge clk);
      prev = int'(pin_val);
      count_high(2 * FPER, h);
      chk("R7 fast reserved holds", h, prev * 2 * FPER);

      // R9 buffered compare in fast PWM
      out_mode = 2'b10;
      wr_cmp(3);
      repeat (3 * FPER) @(negedge clk);
      n = 0;
      prev = int'(pin_val);
      while (!(prev == 0 && pin_val) && n < 100) begin
         prev = int'(pin_val); @(negedge clk); n++;
      end
      cmp_wr_en = 1'b1; cmp_wr_data = W'(10);
      h = 1;
      @(negedge clk);
      cmp_wr_en = 1'b0;
      while (pin_val && h < 100) begin h++; @(negedge clk); end
      chk("R9 old compare kept this period", h, 4);
      while (!pin_val) @(negedge clk);
      h = 0;
      while (pin_val && h < 100) begin h++; @(negedge clk); end
      chk("R9 new compare next period", h, 11);

      // R6 R8 phase-correct sweep
      wave_mode = 2'b11;
      for (int m = 2; m < 4; m++) begin
         out_mode = 2'(m);
         for (int c = 1; c < FPER; c++) begin
            wr_cmp(c);
            repeat (3 * PPER) @(negedge clk);
            count_high(PPER, h);
            chk($sformatf("%s phase mode=%0d c=%0d", (c == FPER - 1) ? "R8" : "R6", m, c),
                h, (m == 2) ? 2 * c : PPER - 2 * c);
         end
      end

      // R7 reserved code in phase-correct
      out_mode = 2'b01;
      @(negedge clk);
      prev = int'(pin_val);
      count_high(2 * PPER, h);
      chk("R7 phase reserved holds", h, prev * 2 * PPER);

      // R1 disconnect in a PWM mode
      out_mode = 2'b00; port_val = 1'b0;
      @(negedge clk);
      chk("R1 disconnected in phase mode", int'(pin_val), 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule